// File: doc/BRIEF.md
# Chained Descriptor Ring DMA Engine

This engine moves 32-bit words from a local FIFO port into system memory. A ring of linked descriptors in memory controls where the words go. Each descriptor is four words long. The engine reads them one word at a time over a simple read port. It then streams data words out over a memory write port with a valid/ready handshake.

The local source address is constant. It is taken from the descriptor and presented unchanged while the data moves. Only the memory address advances. Transfers run in demand mode: a word moves only in a cycle where the FIFO reports data ready and the memory side accepts it.

When a descriptor's byte count is used up, the engine does three things. It emits a one-cycle terminal-count pulse. If that descriptor asks for it, it latches an interrupt. It then follows the link word to the next descriptor. Because the last link points back to the first, the chain never ends by itself. It stops only on abort or on a descriptor error. The live memory address is always visible, so software can tell which descriptor is in flight.

Top module: `dma_ring_engine`

## Requirements
- R1: Out of reset, the outputs `running`, `irq`, `tc_pulse`, `err`, `dr_req` and `mw_valid` are low and `cur_addr` is zero.
- R2: A start pulse clears the memory-address, local-address and remaining-count registers and the pending interrupt. It then checks the descriptor base.
  - If the base has any of its low 4 bits set, the engine raises `err` and stays stopped.
  - Otherwise it runs and reads the descriptor words at base+0, +4, +8 and +12: memory start address, local address, byte count and link word.
- R3: The link word is laid out as follows.
  - Bits [AW-1:4] give the next descriptor address.
  - Bit 0 (descriptor in memory) and bit 2 (local-to-memory direction) must be 1, and bit 3 must be 0.
  - Bit 1 requests an interrupt at terminal count.
  - Any violation raises `err` and stops the engine.
- R4: The byte count is clamped to MAX_BYTES (65536 by default) and rounded down to a multiple of 4. A result of zero raises `err` and stops the engine.
- R5: Each accepted word, where `mw_valid` and `mw_ready` are both high, is written at `cur_addr` with the FIFO data. In the same cycle `src_pop` is asserted and `cur_addr` then advances by 4. `src_port_addr` holds the descriptor's local address throughout.
- R6: `mw_valid` is asserted only while `src_ready` is high. During a stall no word is dropped or repeated, and the transfer resumes at the same address.
- R7: After the last word of a descriptor, `tc_pulse` is high for exactly one cycle. `irq` is set if the descriptor's interrupt flag is set. The engine then fetches the linked descriptor, so a ring runs without end.
- R8: A clear pulse drops `irq` and leaves `running` unchanged. If a new terminal-count interrupt lands in the same cycle as the clear, the new interrupt wins and `irq` stays high.
- R9: An abort stops the engine: no further writes and no descriptor reads. A pending `irq` is kept.
- R10: `err` stays high while the engine is stopped and is cleared only by a start with a valid base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Start pulse |
| ctl_abort | input | 1 | Abort pulse |
| ctl_clr_irq | input | 1 | Clear pending interrupt |
| desc_base | input | AW | First descriptor address |
| running | output | 1 | Channel enabled |
| irq | output | 1 | Pending terminal-count interrupt |
| tc_pulse | output | 1 | One-cycle end-of-descriptor pulse |
| err | output | 1 | Descriptor or base error |
| cur_addr | output | AW | Live memory address |
| src_port_addr | output | AW | Constant local source address |
| dr_req | output | 1 | Descriptor read request |
| dr_addr | output | AW | Descriptor read address |
| dr_valid | input | 1 | Descriptor read data valid |
| dr_data | input | 32 | Descriptor read data |
| src_ready | input | 1 | FIFO has a word |
| src_data | input | 32 | FIFO word |
| src_pop | output | 1 | FIFO word consumed |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | AW | Memory write address |
| mw_data | output | 32 | Memory write data |

## Verification
The collision that matters is between the last word of an interrupting descriptor and a software clear of `irq`. Both land on the same edge.

To provoke it, the bench first clears `irq` and holds back the final word of that descriptor. This leaves the engine stalled one word short. It then releases the word and pulses the clear in the same cycle. The result passes only if `irq` is high afterwards, together with exactly one terminal-count pulse.

A clear with no competing event, checked earlier, confirms that the clear alone does drop the flag.

// File: rtl/dma_ring_engine.sv
module dma_ring_engine #(
  parameter int AW        = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_start,
  input  logic          ctl_abort,
  input  logic          ctl_clr_irq,
  input  logic [AW-1:0] desc_base,
  output logic          running,
  output logic          irq,
  output logic          tc_pulse,
  output logic          err,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] src_port_addr,
  output logic          dr_req,
  output logic [AW-1:0] dr_addr,
  input  logic          dr_valid,
  input  logic [31:0]   dr_data,
  input  logic          src_ready,
  input  logic [31:0]   src_data,
  output logic          src_pop,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [31:0]   mw_data
);
  localparam int CW = $clog2(MAX_BYTES) + 1;
  localparam logic [CW-1:0] MAXV = CW'(MAX_BYTES);
  localparam logic [CW-1:0] WORD = CW'(4);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_t;

  state_t        st;
  logic [1:0]    widx;
  logic [AW-1:0] ptr;
  logic [AW-1:0] loc_addr;
  logic [CW-1:0] rem;
  logic          irq_en;

  logic          fire;
  logic [CW-1:0] clamped;
  logic [CW-1:0] rounded;
  logic          link_bad;
  logic [AW-1:0] next_ptr;

  assign running       = (st != S_IDLE);
  assign dr_req        = (st == S_FETCH);
  assign dr_addr       = ptr | {{(AW-4){1'b0}}, widx, 2'b00};
  assign mw_valid      = (st == S_XFER) && src_ready;
  assign fire          = mw_valid && mw_ready;
  assign src_pop       = fire;
  assign mw_addr       = cur_addr;
  assign mw_data       = src_data;
  assign src_port_addr = loc_addr;

  assign clamped  = (dr_data > 32'(MAX_BYTES)) ? MAXV : dr_data[CW-1:0];
  assign rounded  = {clamped[CW-1:2], 2'b00};
  assign link_bad = dr_data[3] || !dr_data[0] || !dr_data[2];
  assign next_ptr = {dr_data[AW-1:4], 4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      widx     <= '0;
      ptr      <= '0;
      cur_addr <= '0;
      loc_addr <= '0;
      rem      <= '0;
      irq_en   <= 1'b0;
      irq      <= 1'b0;
      tc_pulse <= 1'b0;
      err      <= 1'b0;
    end else begin
      tc_pulse <= 1'b0;
      if (fire) cur_addr <= cur_addr + AW'(4);
      if (ctl_clr_irq) irq <= 1'b0;
      if (ctl_start) begin
        cur_addr <= '0;
        loc_addr <= '0;
        rem      <= '0;
        irq      <= 1'b0;
        irq_en   <= 1'b0;
        widx     <= '0;
        if (desc_base[3:0] != 4'd0) begin
          err <= 1'b1;
          st  <= S_IDLE;
        end else begin
          err <= 1'b0;
          ptr <= desc_base;
          st  <= S_FETCH;
        end
      end else if (ctl_abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_FETCH: if (dr_valid) begin
            widx <= widx + 2'd1;
            case (widx)
              2'd0: cur_addr <= dr_data[AW-1:0];
              2'd1: loc_addr <= dr_data[AW-1:0];
              2'd2: begin
                rem <= rounded;
                if (rounded == '0) begin
                  err <= 1'b1;
                  st  <= S_IDLE;
                end
              end
              default: begin
                irq_en <= dr_data[1];
                ptr    <= next_ptr;
                if (link_bad) begin
                  err <= 1'b1;
                  st  <= S_IDLE;
                end else begin
                  st <= S_XFER;
                end
              end
            endcase
          end
          S_XFER: if (fire) begin
            rem <= rem - WORD;
            if (rem == WORD) begin
              tc_pulse <= 1'b1;
              if (irq_en) irq <= 1'b1;
              st <= S_FETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module dma_ring_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_start,
  input logic          ctl_abort,
  input logic          running,
  input logic          irq,
  input logic          tc_pulse,
  input logic          err,
  input logic [AW-1:0] cur_addr,
  input logic          dr_req,
  input logic          src_ready,
  input logic          mw_valid,
  input logic          mw_ready
);
  // R6
  demand_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> src_ready);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && mw_ready && !ctl_start) |=> cur_addr == $past(cur_addr) + AW'(4));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !dr_req && !(mw_valid && mw_ready) && !ctl_start) |=> cur_addr == $past(cur_addr));

  // R7
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> tc_pulse);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_abort && !ctl_start) |=> (!running && !dr_req && !mw_valid));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start |=> (!irq && cur_addr == '0));

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !running);
endmodule

bind dma_ring_engine dma_ring_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_abort(ctl_abort),
  .running(running), .irq(irq), .tc_pulse(tc_pulse), .err(err),
  .cur_addr(cur_addr), .dr_req(dr_req), .src_ready(src_ready),
  .mw_valid(mw_valid), .mw_ready(mw_ready)
);

// File: tb/dma_ring_engine_bench.sv
`timescale 1ns/1ps
module dma_ring_engine_bench;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_start = 1'b0, ctl_abort = 1'b0, ctl_clr_irq = 1'b0;
  logic [AW-1:0] desc_base = '0;
  logic running, irq, tc_pulse, err;
  logic [AW-1:0] cur_addr, src_port_addr, dr_addr, mw_addr;
  logic dr_req, src_pop, mw_valid;
  logic dr_valid = 1'b0;
  logic [31:0] dr_data = '0;
  logic src_en = 1'b1, have_word = 1'b0;
  logic src_ready;
  logic [31:0] src_data = '0;
  logic mw_ready = 1'b1;
  logic [31:0] mw_data;

  assign src_ready = src_en && have_word;

  always #4 clk = ~clk;

  dma_ring_engine #(.AW(AW)) u_dma_ring_engine (
    .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_abort(ctl_abort),
    .ctl_clr_irq(ctl_clr_irq), .desc_base(desc_base), .running(running),
    .irq(irq), .tc_pulse(tc_pulse), .err(err), .cur_addr(cur_addr),
    .src_port_addr(src_port_addr), .dr_req(dr_req), .dr_addr(dr_addr),
    .dr_valid(dr_valid), .dr_data(dr_data), .src_ready(src_ready),
    .src_data(src_data), .src_pop(src_pop), .mw_valid(mw_valid),
    .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
  );

  logic [31:0] dmem [0:255];
  logic [31:0] srcq[$];
  logic [63:0] expq[$];
  int n_cmp = 0, n_bad = 0, tc_cnt = 0, bp_cnt = 0;
  bit bp_on = 1'b0, pop_pend = 1'b0, finished = 1'b0;
  logic [31:0] wval = 32'hA000_0000;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  // monitor: drives memories and FIFO at negedge, samples 2ns later
  always @(negedge clk) begin
    logic [31:0] junk;
    logic [63:0] e;
    if (pop_pend) begin
      junk = srcq.pop_front();
      pop_pend = 1'b0;
    end
    have_word = (srcq.size() > 0);
    src_data  = have_word ? srcq[0] : 32'h0;
    dr_valid  = dr_req;
    dr_data   = dmem[dr_addr[9:2]];
    bp_cnt++;
    mw_ready  = !bp_on || (bp_cnt % 3 != 0);
    #2;
    if (tc_pulse) tc_cnt++;
    if (mw_valid && mw_ready) begin
      pop_pend = 1'b1;
      if (expq.size() == 0) begin
        chk("R9 unexpected write", mw_addr, 32'hFFFF_FFFF);
      end else begin
        e = expq.pop_front();
        chk("R5 write addr", mw_addr, e[63:32]);
        chk("R5 write data", mw_data, e[31:0]);
        chk("R5 pop", {31'd0, src_pop}, 32'd1);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic push_word(input logic [31:0] addr);
    srcq.push_back(wval);
    expq.push_back({addr, wval});
    wval = wval + 32'd1;
  endtask

  task automatic push_run(input logic [31:0] addr, input int n);
    for (int i = 0; i < n; i++) push_word(addr + 32'(4 * i));
  endtask

  task automatic drain(input int limit);
    int k = 0;
    while (expq.size() > 0 && k < limit) begin step(1); k++; end
    chk("R6 drain", 32'(expq.size()), 32'd0);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] m,
                          input logic [31:0] l, input logic [31:0] s, input logic [31:0] lk);
    dmem[at[9:2]]       = m;
    dmem[at[9:2] + 8'd1] = l;
    dmem[at[9:2] + 8'd2] = s;
    dmem[at[9:2] + 8'd3] = lk;
  endtask

  task automatic pulse_start(input logic [31:0] b);
    desc_base = b;
    ctl_start = 1'b1;
    step(1);
    ctl_start = 1'b0;
  endtask

  task automatic pulse_abort();
    ctl_abort = 1'b1;
    step(1);
    ctl_abort = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int tc0;
    for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
    put_desc(32'h100, 32'h1000, 32'h18, 32'd16,   32'h110 | 32'h7);
    put_desc(32'h110, 32'h2000, 32'h18, 32'h0A,   32'h100 | 32'h5);
    put_desc(32'h200, 32'h8000_0000, 32'h40, 32'h0003_0002, 32'h200 | 32'h7);
    put_desc(32'h300, 32'h3000, 32'h18, 32'd3,    32'h300 | 32'h7);
    put_desc(32'h340, 32'h3400, 32'h18, 32'd8,    32'h340 | 32'h3);
    put_desc(32'h380, 32'h3800, 32'h18, 32'd8,    32'h380 | 32'hF);

    step(3);
    // R1 reset state
    chk("R1 running", {31'd0, running}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 tc", {31'd0, tc_pulse}, 32'd0);
    chk("R1 cur_addr", cur_addr, 32'd0);
    chk("R1 dr_req", {31'd0, dr_req}, 32'd0);
    chk("R1 mw_valid", {31'd0, mw_valid}, 32'd0);
    rst_n = 1'b1;
    step(1);

    // R2 misaligned base
    pulse_start(32'h104);
    chk("R2 bad base err", {31'd0, err}, 32'd1);
    chk("R2 bad base running", {31'd0, running}, 32'd0);
    step(2);
    chk("R2 bad base no fetch", {31'd0, dr_req}, 32'd0);

    // R2 good start, R10 err cleared
    pulse_start(32'h100);
    chk("R10 err cleared", {31'd0, err}, 32'd0);
    chk("R2 running", {31'd0, running}, 32'd1);
    chk("R2 cur_addr zeroed", cur_addr, 32'd0);

    // lap 1 with backpressure; R4 rounding 0x0A -> 2 words
    bp_on = 1'b1;
    push_run(32'h1000, 4);
    push_run(32'h2000, 2);
    drain(200);
    step(3);
    chk("R7 tc count lap1", 32'(tc_cnt), 32'd2);
    chk("R7 irq set", {31'd0, irq}, 32'd1);
    chk("R5 local addr", src_port_addr, 32'h18);

    // R8 clear alone
    ctl_clr_irq = 1'b1;
    step(1);
    ctl_clr_irq = 1'b0;
    chk("R8 clr irq", {31'd0, irq}, 32'd0);
    chk("R8 clr keeps running", {31'd0, running}, 32'd1);

    // R6 stall one word short
    bp_on = 1'b0;
    push_run(32'h1000, 3);
    drain(100);
    src_en = 1'b0;
    push_word(32'h100C);
    step(3);
    chk("R6 stall no valid", {31'd0, mw_valid}, 32'd0);
    chk("R6 stall addr held", cur_addr, 32'h100C);
    chk("R6 stall no tc", 32'(tc_cnt), 32'd2);

    // R8 terminal count and clear on the same edge
    src_en = 1'b1;
    ctl_clr_irq = 1'b1;
    step(1);
    ctl_clr_irq = 1'b0;
    chk("R8 set wins irq", {31'd0, irq}, 32'd1);
    chk("R7 tc pulse", {31'd0, tc_pulse}, 32'd1);
    step(1);
    chk("R7 tc one cycle", {31'd0, tc_pulse}, 32'd0);

    // R7 ring wraps: B then A again
    bp_on = 1'b1;
    push_run(32'h2000, 2);
    push_run(32'h1000, 4);
    drain(200);
    step(3);
    chk("R7 tc count wrap", 32'(tc_cnt), 32'd5);

    // R9 abort while stalled
    src_en = 1'b0;
    srcq.push_back(32'hDEAD_BEEF);
    step(2);
    pulse_abort();
    chk("R9 abort running", {31'd0, running}, 32'd0);
    src_en = 1'b1;
    step(4);
    chk("R9 abort no write", {31'd0, mw_valid}, 32'd0);
    chk("R9 abort no fetch", {31'd0, dr_req}, 32'd0);
    chk("R9 abort keeps irq", {31'd0, irq}, 32'd1);
    srcq.delete();
    step(2);

    // R2 restart zeroes registers and irq
    pulse_start(32'h100);
    chk("R2 restart cur_addr", cur_addr, 32'd0);
    chk("R2 restart local", src_port_addr, 32'd0);
    chk("R2 restart irq", {31'd0, irq}, 32'd0);
    step(2);
    pulse_abort();
    step(2);

    // R4 clamp to 64 KiB
    bp_on = 1'b0;
    tc0 = tc_cnt;
    pulse_start(32'h200);
    push_run(32'h8000_0000, 16384);
    drain(40000);
    step(3);
    chk("R4 clamp tc", 32'(tc_cnt - tc0), 32'd1);
    chk("R5 local addr 2", src_port_addr, 32'h40);
    step(6);
    chk("R7 self ring refetch", cur_addr, 32'h8000_0000);
    pulse_abort();
    step(2);

    // R4 zero size
    pulse_start(32'h300);
    step(8);
    chk("R4 zero size err", {31'd0, err}, 32'd1);
    chk("R4 zero size stop", {31'd0, running}, 32'd0);
    step(5);
    chk("R10 err sticky", {31'd0, err}, 32'd1);

    // R3 bad link flags
    pulse_start(32'h340);
    step(8);
    chk("R3 missing dir flag", {31'd0, err}, 32'd1);
    pulse_start(32'h380);
    step(8);
    chk("R3 bit3 set", {31'd0, err}, 32'd1);
    chk("R3 stopped", {31'd0, running}, 32'd0);

    pulse_start(32'h100);
    chk("R10 err cleared again", {31'd0, err}, 32'd0);
    step(2);
    pulse_abort();
    step(2);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule